// File: doc/BRIEF.md
# Read Port Undefined-Data Injector

This block sits on the read side of a synchronous memory model. When a read has no defined result, it returns pseudo-random data instead of the memory contents. Without it, the model would quietly return stale, aliased or half-written data. Three kinds of read have no defined result:

- a read issued while the port is switched off;
- a read whose address lies past the last word of a memory whose depth is not a power of two;
- a read that hits the same address as an active write on any write port.

Each kind raises a one-bit hazard condition, and the three conditions are ORed into one flag. A shift chain as long as the read latency delays that flag, so the flag reaches the output stage in the same cycle as the read's data. While the delayed flag is high, the output carries bits from an internal 32-bit LFSR. Otherwise the raw read data passes through unchanged. A design or formal environment instantiates the block between the memory array's read data and its consumer. That environment cannot then depend on undefined read behaviour without the dependence showing up as corrupted data.

Parameters set the depth, the data width, the read latency and the number of write ports. Further parameters set the LFSR seed, whether the read enable is hard-tied high, and which hazard classes are active.

Top module: `rd_undef_guard`

## Requirements
- R1: In reset (`rst_n` low, asynchronous) the LFSR loads the seed, or 1 if the seed is zero, and every latency stage clears. The first cycle after reset therefore passes `rd_raw` to `rd_data`.
- R2: A read cycle with `rd_en` low is a disabled read and raises the hazard condition, when that class is enabled.
- R3: When DEPTH is not a power of two, a cycle with the read enabled and `rd_addr` greater than DEPTH-1 raises the hazard condition. When DEPTH is a power of two, no such check exists.
- R4: For each write port i, a collision is the read enabled, `wr_en[i]` AND `wr_mask[i]` high, and `wr_addr[i*AW +: AW]` equal to `rd_addr`. Any collision raises the hazard condition. A write whose mask bit is low, or whose address differs, causes none.
- R5: With LAT at 1 or more, the hazard condition of read cycle t selects the output in cycle t+LAT, through LAT registers. With LAT = 0 it selects the output in the same cycle, combinationally.
- R6: While the delayed flag is high, `rd_data` equals bits [DW-1:0] of the LFSR state, with the state repeated when DW is over 32. Otherwise `rd_data` equals `rd_raw`.
- R7: The LFSR shifts left, with the new bit 0 equal to s[31]^s[21]^s[1]^s[0]. It steps on a clock edge only when the delayed flag is high, and otherwise holds.
- R8: Each hazard class has its own enable parameter. A disabled class never raises the flag. With all three disabled, `rd_data` always equals `rd_raw`.
- R9: With the read enable declared tied high, `rd_en` is ignored: the disabled-read check is removed, and the other checks treat the read as enabled.
- R10: An enabled, in-range read with no colliding write returns `rd_raw` unchanged in its output cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read enable |
| rd_addr | input | AW | Read address, AW = clog2(DEPTH) |
| rd_raw | input | DW | Data coming from the memory array for the current output cycle |
| wr_en | input | NWR | Per write port enable |
| wr_mask | input | NWR | Per write port mask bit |
| wr_addr | input | NWR*AW | Write addresses, port i at [i*AW +: AW] |
| rd_data | output | DW | Read data, randomized when the read was undefined |

## Verification
Three instances run from the same stimulus:

- a one-cycle-latency instance with every class active and a depth of six;
- a zero-latency instance with the read enable tied high and the out-of-range class switched off;
- a two-cycle instance with every class switched off.

Clean reads, disabled reads, reads past depth, and collisions on each write port show which condition sets the flag. Collisions with the mask bit low or with a differing address show that the full collision term is required. Bursts of hazard reads, and clean reads placed between them, separate a correct per-flag LFSR step and one-cycle delay from a free-running source or a misaligned pipeline. The tied and all-disabled instances show which checks each parameter removes.

// File: rtl/rd_undef_guard.sv
`timescale 1ns/1ps
module rd_undef_guard #(
  parameter int          DEPTH      = 6,
  parameter int          DW         = 16,
  parameter int          LAT        = 1,
  parameter int          NWR        = 2,
  parameter bit          EN_DIS     = 1'b1,
  parameter bit          EN_OOB     = 1'b1,
  parameter bit          EN_RWC     = 1'b1,
  parameter bit          RD_EN_TIED = 1'b0,
  parameter logic [31:0] SEED       = 32'h1D87_2B41,
  localparam int         AW         = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  input  logic [DW-1:0]     rd_raw,
  input  logic [NWR-1:0]    wr_en,
  input  logic [NWR-1:0]    wr_mask,
  input  logic [NWR*AW-1:0] wr_addr,
  output logic [DW-1:0]     rd_data
);

  localparam bit          NON_POW2 = (DEPTH & (DEPTH - 1)) != 0;
  localparam logic [31:0] SEED_NZ  = (SEED == 32'd0) ? 32'd1 : SEED;

  logic           rd_on, dis_hit, oob_hit, rwc_hit, flag_now, sel;
  logic [NWR-1:0] col;
  logic [31:0]    lfsr;
  logic [DW-1:0]  rnd;

  assign rd_on   = RD_EN_TIED ? 1'b1 : rd_en;
  assign dis_hit = EN_DIS && !RD_EN_TIED && !rd_en;

  generate
    if (EN_OOB && NON_POW2) begin : g_oob
      assign oob_hit = rd_on && (rd_addr > AW'(DEPTH - 1));
    end else begin : g_no_oob
      assign oob_hit = 1'b0;
    end
  endgenerate

  for (genvar i = 0; i < NWR; i++) begin : g_col
    assign col[i] = wr_en[i] && wr_mask[i] && (wr_addr[i*AW +: AW] == rd_addr);
  end
  assign rwc_hit  = EN_RWC && rd_on && (|col);
  assign flag_now = dis_hit || oob_hit || rwc_hit;

  generate
    if (LAT == 0) begin : g_comb
      assign sel = flag_now;
    end else begin : g_pipe
      logic [LAT-1:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else begin
          pipe_q[0] <= flag_now;
          for (int k = 1; k < LAT; k++) pipe_q[k] <= pipe_q[k-1];
        end
      end
      assign sel = pipe_q[LAT-1];

      a_r5_stage0: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pipe_q[0] == $past(flag_now));
      for (genvar s = 1; s < LAT; s++) begin : g_stage_chk
        a_r5_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
          1'b1 |=> pipe_q[s] == $past(pipe_q[s-1]));
      end
      if (EN_DIS && !RD_EN_TIED) begin : g_dis_chk
        a_r2_disabled_flag: assert property (@(posedge clk) disable iff (!rst_n)
          !rd_en |=> pipe_q[0]);
      end
      if (EN_RWC) begin : g_rwc_chk
        a_r4_collision_flag: assert property (@(posedge clk) disable iff (!rst_n)
          (rd_on && (|(wr_en & wr_mask)) && (col != '0)) |=> pipe_q[0]);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   lfsr <= SEED_NZ;
    else if (sel) lfsr <= {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  end

  for (genvar j = 0; j < DW; j++) begin : g_rnd
    assign rnd[j] = lfsr[j % 32];
  end

  assign rd_data = sel ? rnd : rd_raw;

  a_r7_lfsr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(lfsr));
  a_r7_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 32'd0);
  a_r8_no_class_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!EN_DIS && !EN_OOB && !EN_RWC) |-> rd_data == rd_raw);

endmodule

// File: tb/test_rd_undef_guard.sv
`timescale 1ns/1ps
module test_rd_undef_guard;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam logic [31:0] S0 = 32'h1D87_2B41;
  localparam logic [31:0] S1 = 32'h0000_BEEF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_en = 1'b1;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_raw = 16'h1234;
  logic [1:0] wr_en = '0, wr_mask = '0;
  logic [2*AW-1:0] wr_addr = '0;
  logic [DW-1:0] d0, d1, d2;

  int n_run = 0, n_fail = 0;
  logic [31:0] m0, m1;

  always #2 clk = ~clk;

  rd_undef_guard #(.DEPTH(6), .DW(DW), .LAT(1), .NWR(2), .SEED(S0)) i_rd_undef_guard (
    .clk, .rst_n, .rd_en, .rd_addr, .rd_raw, .wr_en, .wr_mask, .wr_addr, .rd_data(d0));
  rd_undef_guard #(.DEPTH(6), .DW(DW), .LAT(0), .NWR(2), .EN_OOB(1'b0), .RD_EN_TIED(1'b1),
                   .SEED(S1)) i_rd_undef_guard_lat0 (
    .clk, .rst_n, .rd_en, .rd_addr, .rd_raw, .wr_en, .wr_mask, .wr_addr, .rd_data(d1));
  rd_undef_guard #(.DEPTH(6), .DW(DW), .LAT(2), .NWR(2), .EN_DIS(1'b0), .EN_OOB(1'b0),
                   .EN_RWC(1'b0)) i_rd_undef_guard_off (
    .clk, .rst_n, .rd_en, .rd_addr, .rd_raw, .wr_en, .wr_mask, .wr_addr, .rd_data(d2));

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic chk(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string tag);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one read cycle on all instances, checked at the output cycle of each
  task automatic do_read(input logic en, input logic [AW-1:0] a,
                         input logic e0, input logic k0, input logic [AW-1:0] a0,
                         input logic e1, input logic k1, input logic [AW-1:0] a1,
                         input string tag);
    logic hit, f0, f1;
    logic [DW-1:0] ra, rb;
    ra  = 16'hA500 ^ 16'(n_run);
    rb  = 16'h3C00 ^ 16'(n_run * 7);
    hit = (e0 && k0 && a0 == a) || (e1 && k1 && a1 == a);
    f0  = !en || (a > 3'd5) || hit;
    f1  = hit;
    @(negedge clk);
    rd_en = en; rd_addr = a; rd_raw = ra;
    wr_en = {e1, e0}; wr_mask = {k1, k0}; wr_addr = {a1, a0};
    #0.5;
    chk(d1, f1 ? m1[DW-1:0] : ra, {tag, " lat0"});
    @(posedge clk);
    if (f1) m1 = step(m1);
    #0.5 rd_raw = rb;
    #0.5;
    chk(d0, f0 ? m0[DW-1:0] : rb, {tag, " lat1"});
    chk(d2, rb, {tag, " R8 off"});
    if (f0) m0 = step(m0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m0 = S0; m1 = S1;
    #0.5;
    chk(d0, rd_raw, "R1 reset lat1");
    chk(d1, rd_raw, "R1 reset lat0");
    chk(d2, rd_raw, "R1 reset off");
  endtask

  task automatic t_disabled;
    do_read(1'b0, 3'd2, 0, 0, 0, 0, 0, 0, "R2 R9 R6 R7 disabled, first seed bits");
    do_read(1'b0, 3'd7, 0, 0, 0, 0, 0, 0, "R2 R9 disabled, addr 7");
  endtask

  task automatic t_oob;
    do_read(1'b1, 3'd6, 0, 0, 0, 0, 0, 0, "R3 addr 6");
    do_read(1'b1, 3'd7, 0, 0, 0, 0, 0, 0, "R3 addr 7");
    do_read(1'b1, 3'd5, 0, 0, 0, 0, 0, 0, "R3 R10 last word");
  endtask

  task automatic t_collide;
    do_read(1'b1, 3'd3, 1, 1, 3'd3, 0, 0, 0, "R4 port0");
    do_read(1'b1, 3'd1, 0, 0, 0, 1, 1, 3'd1, "R4 port1");
    do_read(1'b1, 3'd3, 1, 0, 3'd3, 0, 1, 3'd3, "R4 mask off");
    do_read(1'b1, 3'd3, 1, 1, 3'd4, 1, 1, 3'd2, "R4 addr differs");
    do_read(1'b0, 3'd4, 1, 1, 3'd4, 0, 0, 0, "R9 R4 tied enable collides");
  endtask

  task automatic t_latency;
    do_read(1'b0, 3'd0, 0, 0, 0, 0, 0, 0, "R5 hazard then");
    do_read(1'b1, 3'd0, 0, 0, 0, 0, 0, 0, "R5 R10 clean follows");
    do_read(1'b1, 3'd2, 0, 0, 0, 0, 0, 0, "R10 clean");
  endtask

  task automatic t_burst;
    for (int i = 0; i < 6; i++)
      do_read(1'b0, 3'(i), 1, 1, 3'(i), 0, 0, 0, "R7 burst");
  endtask

  initial begin
    m0 = S0; m1 = S1;
    t_reset();
    t_disabled();
    t_oob();
    t_collide();
    t_latency();
    t_burst();
    t_latency();
    t_reset();
    do_read(1'b0, 3'd0, 0, 0, 0, 0, 0, 0, "R1 seed reloaded");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #40000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule